// File: doc/BRIEF.md
# Serial Gamepad Poller

The block reads a sixteen-button serial gamepad over three general-purpose pads: a latch output, a clock output and a data input. A free-running timer asks for a fresh sample at a fixed rate, nominally 60 times a second. A divider derives the slow controller clock from the system clock. A small state machine waits for the next controller-clock period boundary. It then raises the latch for one full controller-clock period and issues sixteen clock pulses, capturing one data bit on each rising edge.

The pad reports pressed buttons as low levels. The block inverts them and publishes the sixteen-bit word in a register that the processor reads at offset zero of its address window. That register changes in a single cycle, and only after the sixteenth bit is in. A read therefore always returns a word from one complete sample, never a mix of two.

Top module: `pad_poller`

## Requirements
- R1: While reset is asserted and right after it, the latch pad is low, the clock pad is high and the published register reads zero.
- R2: Polls repeat with a fixed spacing of POLL_CYC system cycles between latch rising edges, provided POLL_CYC is a multiple of 2*HALF_CYC.
- R3: A latch pulse starts only on a controller-clock period boundary, that is, on the system edge numbered a non-zero multiple of 2*HALF_CYC, counting from the last edge before reset is released as edge zero.
- R4: The latch pulse lasts 2*HALF_CYC system cycles, and the clock pad stays high throughout it.
- R5: Each poll issues exactly 16 clock pulses after the latch falls, each with a low phase of HALF_CYC cycles followed by a high phase of HALF_CYC cycles. The bit counter never exceeds 16.
- R6: The data pad is sampled at each rising clock edge. The first bit, which is present right after the latch, lands in register bit 0 and the sixteenth in bit 15. A low level on the pad reads back as 1.
- R7: The published register keeps its previous value during a poll and changes only on the cycle the sixteenth bit is captured.
- R8: A read strobe with address 0 returns the published register on the next cycle. Any other address returns zero.
- R9: Between polls, the latch pad is low and the clock pad is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pad_latch | output | 1 | Latch request to the gamepad |
| pad_clk | output | 1 | Shift clock to the gamepad, idle high |
| pad_data | input | 1 | Serial button data from the gamepad, active-low, asynchronous |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address within the peripheral window |
| rd_data | output | 16 | Read data, registered |

## Verification
The bench builds the block with HALF_CYC=4 and POLL_CYC=400, so one poll takes 136 cycles and a poll starts every 400 cycles. At these values the alignment arithmetic, the exact poll spacing, the pulse widths and a read taken in the middle of a poll can all be timed exactly from the bench. Eight polls then run in a few thousand cycles. A behavioural pad model loads its shift register on the latch and shifts on each clock rise, so the bit order and the inversion are checked end to end.

// File: rtl/pad_poller.sv
module pad_poller #(
  parameter int HALF_CYC = 300,
  parameter int POLL_CYC = 833_333,
  parameter int NBITS    = 16,
  parameter int ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              pad_latch,
  output logic              pad_clk,
  input  logic              pad_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [NBITS-1:0]  rd_data
);
  localparam int DW = (HALF_CYC > 2) ? $clog2(HALF_CYC) : 1;
  localparam int PW = (POLL_CYC > 2) ? $clog2(POLL_CYC) : 1;
  localparam int BW = $clog2(NBITS + 1);

  typedef enum logic [1:0] {S_IDLE, S_LATCH, S_SHIFT} st_t;

  st_t             state;
  logic [DW-1:0]   dcnt;
  logic            ph;
  logic [PW-1:0]   pcnt;
  logic            pend;
  logic            d1, d2;
  logic            lhalf;
  logic [BW-1:0]   nbit;
  logic [NBITS-1:0] sh, buttons;

  wire tick  = (dcnt == DW'(HALF_CYC - 1));
  wire bound = tick && ph;
  wire fire  = (pcnt == PW'(POLL_CYC - 1));
  wire start = (state == S_IDLE) && pend && bound;
  wire last  = (nbit == BW'(NBITS - 1));
  wire [NBITS-1:0] sh_next = {d2, sh[NBITS-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dcnt <= '0;
      ph   <= 1'b0;
    end else if (tick) begin
      dcnt <= '0;
      ph   <= ~ph;
    end else begin
      dcnt <= dcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     pcnt <= '0;
    else if (fire)  pcnt <= '0;
    else            pcnt <= pcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      pend <= 1'b0;
    else if (fire)   pend <= 1'b1;
    else if (start)  pend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d1 <= 1'b1;
      d2 <= 1'b1;
    end else begin
      d1 <= pad_data;
      d2 <= d1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      pad_latch <= 1'b0;
      pad_clk   <= 1'b1;
      lhalf     <= 1'b0;
      nbit      <= '0;
      sh        <= '0;
      buttons   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          pad_latch <= 1'b1;
          lhalf     <= 1'b0;
          state     <= S_LATCH;
        end
        S_LATCH: if (tick) begin
          if (lhalf) begin
            pad_latch <= 1'b0;
            nbit      <= '0;
            state     <= S_SHIFT;
          end else begin
            lhalf <= 1'b1;
          end
        end
        S_SHIFT: if (tick) begin
          if (pad_clk) begin
            pad_clk <= 1'b0;
          end else begin
            pad_clk <= 1'b1;
            sh      <= sh_next;
            nbit    <= nbit + 1'b1;
            if (last) begin
              buttons <= ~sh_next;
              state   <= S_IDLE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rd_data <= '0;
    else if (rd_en)  rd_data <= (rd_addr == '0) ? buttons : '0;
  end

  a_r4_latch_clk_high: assert property (@(posedge clk) disable iff (!rst_n)
    pad_latch |-> pad_clk);

  a_r9_idle_levels: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> (!pad_latch && pad_clk));

  a_r7_atomic: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_SHIFT) |=> $stable(buttons));

  a_r5_bit_bound: assert property (@(posedge clk) disable iff (!rst_n)
    nbit <= BW'(NBITS));

  a_r3_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pad_latch) |-> $past(bound));

  a_r8_other_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr != '0) |=> (rd_data == '0));
endmodule

// File: tb/sim_pad_poller.sv
module sim_pad_poller;
  localparam int PER   = 10;
  localparam int HALF  = 4;
  localparam int POLL  = 400;
  localparam int AW    = 4;
  localparam int NV    = 8;

  // {raw word driven on the pad line (bit0 first, low = pressed), expected register}
  localparam logic [31:0] VEC [NV] = '{
    {16'hFFFF, 16'h0000},
    {16'h0000, 16'hFFFF},
    {16'hFFFE, 16'h0001},
    {16'h7FFF, 16'h8000},
    {16'h5A3C, 16'hA5C3},
    {16'hA5C3, 16'h5A3C},
    {16'hF0F0, 16'h0F0F},
    {16'hEDCB, 16'h1234}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pad_latch, pad_clk;
  logic pad_data;
  logic rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [15:0] rd_data;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [15:0] raw = 16'hFFFF;
  logic [15:0] psh = 16'hFFFF;
  time t_ref, t_lr, t_lr_prev, t_cf;
  int lat_w, clk_low, npulse;
  logic [15:0] v;

  always #(PER/2) clk = ~clk;

  pad_poller #(.HALF_CYC(HALF), .POLL_CYC(POLL), .NBITS(16), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .pad_latch(pad_latch), .pad_clk(pad_clk),
    .pad_data(pad_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data));

  assign pad_data = psh[0];

  always @(posedge pad_latch or posedge pad_clk)
    if (pad_latch) psh <= raw;
    else           psh <= {1'b1, psh[15:1]};

  always @(posedge pad_latch) begin
    t_lr_prev = t_lr;
    t_lr = $time;
  end
  always @(negedge pad_latch) lat_w = int'(($time - t_lr) / PER);
  always @(negedge pad_clk) t_cf = $time;
  always @(posedge pad_latch or posedge pad_clk)
    if (pad_latch) npulse = 0;
    else begin
      npulse = npulse + 1;
      clk_low = int'(($time - t_cf) / PER);
    end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_en = 1'b1;
    rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic wait_poll();
    @(posedge pad_latch);
    repeat (16) @(posedge pad_clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 latch in reset", 32'(pad_latch), 32'd0);
    check("R1 clk in reset", 32'(pad_clk), 32'd1);
    rst_n = 1'b1;
    t_ref = $time - PER/2;
    rd(0, v);
    check("R1 register after reset", 32'(v), 32'd0);

    for (int i = 0; i < NV; i++) begin
      raw = VEC[i][31:16];
      wait_poll();
      rd(0, v);
      check("R6 captured word", 32'(v), 32'(VEC[i][15:0]));
      check("R5 pulse count", 32'(npulse), 32'd16);
      check("R5 clock low width", 32'(clk_low), 32'(HALF));
      check("R4 latch width", 32'(lat_w), 32'(2*HALF));
      check("R3 alignment", 32'(int'((t_lr - t_ref) / PER) % (2*HALF)), 32'd0);
      check("R9 idle levels", {pad_latch, pad_clk}, 32'b01);
      if (i > 0) check("R2 spacing", 32'(int'((t_lr - t_lr_prev) / PER)), 32'(POLL));
    end

    rd(5, v);
    check("R8 other address", 32'(v), 32'd0);
    rd(0, v);
    check("R8 base address", 32'(v), 32'h1234);

    raw = 16'h0F0F;
    @(posedge pad_latch);
    repeat (8) @(posedge pad_clk);
    rd(0, v);
    check("R7 mid-poll old value", 32'(v), 32'h1234);
    repeat (8) @(posedge pad_clk);
    repeat (3) @(negedge clk);
    rd(0, v);
    check("R7 new value after poll", 32'(v), 32'hF0F0);

    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 latch on re-reset", 32'(pad_latch), 32'd0);
    rd(0, v);
    check("R1 register on re-reset", 32'(v), 32'd0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule